// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Writes

This block is a single-port synchronous static memory intended as the data array of a secondary cache. All inputs except the output enable are sampled on the rising clock edge. A cycle starts a transfer when chip enable is high and either of two start strobes is high. One strobe is the processor's and the other is the cache controller's. The external address is loaded at that edge.

The following beats of a four-beat burst take their address from an internal 2-bit offset counter. That counter moves forward only on cycles where the advance input is high. Writes take effect at the clock edge that samples them and need no external pulse shaping. Each 9-bit lane of the word has its own write enable.

Reads return data one clock after the address is sampled. The shared data pins are split into an input bus, an output bus and an output-drive qualifier. The qualifier combines the registered read-valid state with the asynchronous output enable. The full-size array is built with `ADDR_W = 16`, which gives 65,536 words of 18 bits. The default is smaller so that elaboration stays light.

Control and data pins are plain levels sampled each cycle. There is no valid/ready handshake and no back-pressure: every transfer issued is accepted in the cycle it is presented.

Top module: `burst_sram`

## Requirements
- R1: After reset no burst is active and `dout_en` is 0, even with `oe` high.
- R2: On an edge where `ce` is 1 and either `ts_cpu` or `ts_ctl` is 1, the block loads `addr`, starts a burst and performs an access at `addr`. Either strobe alone suffices.
- R3: With `ce` at 0, the start strobes are ignored: no write happens, no read data is presented, and no burst starts.
- R4: While a burst is active, an edge with `adv` at 1 (and no start) accesses the next address. That address is formed by adding 1 modulo 4 to bits [1:0] while bits [ADDR_W-1:2] stay fixed, so the burst wraps inside its aligned group of four.
- R5: When a start and `adv` are both high on the same edge, the start wins and the access goes to the new external address.
- R6: A burst covers four beats. After its third advance it ends, and a further `adv` does nothing: it neither writes nor presents data.
- R7: `adv` with no burst active is ignored. Inside a burst, a cycle with neither start nor `adv` makes no access and keeps the burst position.
- R8: An access writes when any bit of `lane_we` is 1. Bit 0 writes data bits [8:0] and bit 1 writes bits [17:9]. A lane whose enable is 0 keeps its stored value.
- R9: An access with `lane_we` = 0 is a read. Its data appears on `dout` after the next rising edge, and `dout_en` is then 1 if `oe` is 1.
- R10: `oe` acts without a clock: while `oe` is 0, `dout_en` is 0, and raising it restores the drive within the same cycle.
- R11: `dout_en` is 0 for as long as a write access is presented at the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| addr | input | ADDR_W | External word address, loaded on a start |
| ce | input | 1 | Chip enable, qualifies the start strobes |
| ts_cpu | input | 1 | Processor transfer start |
| ts_ctl | input | 1 | Cache-controller transfer start |
| adv | input | 1 | Burst advance |
| lane_we | input | LANES | Per-lane write enables, bit 0 = low lane |
| oe | input | 1 | Asynchronous output enable |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Drive qualifier for the shared data pins |

## Verification
The bench builds the block with `ADDR_W = 6`, `LANE_W = 9` and `LANES = 2`, which gives a 64-word array the bench can cover completely. It fills every word with bursts that start at rotating offsets and use alternating strobes. It then starts a read burst at every one of the 64 addresses, which exercises the wrap from each of the four offsets in every group. The small depth also places lane-only writes, ignored advances and start/advance collisions at addresses whose prior contents the bench knows exactly.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int OFS_W     = 2;
  localparam int BURST_LEN = 1 << OFS_W;
  localparam int LEFT_W    = OFS_W;

  function automatic logic [OFS_W-1:0] wrap_inc(input logic [OFS_W-1:0] ofs);
    return ofs + OFS_W'(1);
  endfunction
endpackage

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int AW = 10,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce,
  input  logic              ts_cpu,
  input  logic              ts_ctl,
  input  logic              adv,
  output logic              acc,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] cur_q;
  logic              active_q;
  logic [LEFT_W-1:0] left_q;
  logic              start, step;

  assign start = ce & (ts_cpu | ts_ctl);
  assign step  = adv & active_q & ~start;
  assign acc   = start | step;

  always_comb begin
    if (start) eff_addr = addr;
    else       eff_addr = {cur_q[ADDR_W-1:OFS_W], wrap_inc(cur_q[OFS_W-1:0])};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (start) begin
      cur_q    <= addr;
      active_q <= 1'b1;
      left_q   <= LEFT_W'(BURST_LEN - 1);
    end else if (step) begin
      cur_q  <= eff_addr;
      left_q <= left_q - LEFT_W'(1);
      if (left_q == LEFT_W'(1)) active_q <= 1'b0;
    end
  end

  // R4: advance keeps the upper bits and steps the offset modulo 4
  a_r4_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_q[ADDR_W-1:OFS_W] == $past(cur_q[ADDR_W-1:OFS_W])) &&
             (cur_q[OFS_W-1:0] == $past(cur_q[OFS_W-1:0]) + OFS_W'(1)));

  // R5: a start, even together with adv, loads the external address
  a_r5_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && adv) |=> (cur_q == $past(addr)) && active_q);

  // R6: third advance closes the burst
  a_r6_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step && left_q == LEFT_W'(1)) |=> !active_q);

  // R3 / R7: no start and no live burst means no access
  a_r7_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !active_q) |-> !acc);

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the offset width");
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce,
  input  logic                    ts_cpu,
  input  logic                    ts_ctl,
  input  logic                    adv,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    oe,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;

  logic              acc;
  logic [ADDR_W-1:0] eff_addr;
  logic              wr_now;
  logic              rd_req_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              dval_q;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ce       (ce),
    .ts_cpu   (ts_cpu),
    .ts_ctl   (ts_ctl),
    .adv      (adv),
    .acc      (acc),
    .eff_addr (eff_addr)
  );

  assign wr_now = acc & (|lane_we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      dval_q    <= 1'b0;
    end else begin
      rd_req_q <= acc & ~(|lane_we);
      if (acc) rd_addr_q <= eff_addr;
      dval_q   <= rd_req_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane #(.AW(ADDR_W), .W(LANE_W)) u_lane (
      .clk     (clk),
      .wr_en   (acc & lane_we[l]),
      .wr_addr (eff_addr),
      .wr_data (din[l*LANE_W +: LANE_W]),
      .rd_en   (rd_req_q),
      .rd_addr (rd_addr_q),
      .rd_data (dout[l*LANE_W +: LANE_W])
    );
  end

  assign dout_en = oe & dval_q & ~wr_now;

  // R9: presented data belongs to a read issued two edges earlier
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    dval_q |-> $past(acc && !(|lane_we), 2));

  // R11: pins are never driven while a write is presented
  a_r11_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && |lane_we) |-> !dout_en);

  // R10: output drive needs the asynchronous enable
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> oe);

  if (DATA_W < 2) begin : g_bad_data
    initial $error("data word too narrow");
  end
endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/100ps
module test_burst_sram;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          ce, ts_cpu, ts_ctl, adv, oe;
  logic [NL-1:0] lane_we;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  logic [DW-1:0] model [NW];
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce(ce), .ts_cpu(ts_cpu),
    .ts_ctl(ts_ctl), .adv(adv), .lane_we(lane_we), .oe(oe), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 1237 + salt * 77 + 5) ^ (a << 9));
  endfunction

  function automatic int nxt(int a);
    return (a & ~3) | ((a + 1) & 3);
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] we);
    logic [DW-1:0] r = old;
    if (we[0]) r[LW-1:0]  = nw[LW-1:0];
    if (we[1]) r[DW-1:LW] = nw[DW-1:LW];
    return r;
  endfunction

  task automatic idle_in();
    ce = 0; ts_cpu = 0; ts_ctl = 0; adv = 0; lane_we = '0; din = '0; addr = '0;
  endtask

  task automatic issue(bit c, bit tc, bit tl, int a, bit ad, logic [NL-1:0] we, logic [DW-1:0] d);
    ce = c; ts_cpu = tc; ts_ctl = tl; addr = AW'(a); adv = ad; lane_we = we; din = d;
    @(negedge clk);
    idle_in();
  endtask

  task automatic check(string req, logic [DW-1:0] exp, bit exp_en);
    checks++;
    if (dout_en !== exp_en || (exp_en && dout !== exp)) begin
      fails++;
      $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", req, dout, dout_en, exp, exp_en);
    end
  endtask

  // read access already issued; wait for data edge and compare
  task automatic expect_data(string req, int a);
    @(negedge clk);
    check(req, model[a], 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int a;
    logic [DW-1:0] d;
    idle_in();
    oe = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset drive", '0, 1'b0);

    // R7: advance with no burst after reset makes no read
    issue(0, 0, 0, 0, 1, 2'b00, '0);
    @(negedge clk);
    check("R7 adv without burst", '0, 1'b0);

    // fill all words: rotating start offsets, alternating strobes (R2, R4)
    for (int g = 0; g < NW / 4; g++) begin
      a = 4 * g + (g % 4);
      d = pat(a, 0);
      issue(1, (g % 2) == 0, (g % 2) == 1, a, 0, 2'b11, d);
      model[a] = d;
      for (int b = 1; b < 4; b++) begin
        if (g % 2 == 1) @(negedge clk); // R7 hold cycle inside burst
        a = nxt(a);
        d = pat(a, 0);
        issue(0, 0, 0, 0, 1, 2'b11, d);
        model[a] = d;
      end
    end

    // read bursts from every start address (R2, R4, R9)
    for (int s = 0; s < NW; s++) begin
      a = s;
      issue(1, (s % 2) == 1, (s % 2) == 0, a, 0, 2'b00, '0);
      expect_data("R2 burst start read", a);
      for (int b = 1; b < 4; b++) begin
        a = nxt(a);
        issue(0, 0, 0, 0, 1, 2'b00, '0);
        expect_data("R4 wrap read", a);
      end
    end

    // R6: fourth advance after a full burst is ignored
    a = 5;
    issue(1, 1, 0, a, 0, 2'b00, '0);
    expect_data("R9 read latency", a);
    for (int b = 1; b < 4; b++) begin
      a = nxt(a);
      issue(0, 0, 0, 0, 1, 2'b00, '0);
      expect_data("R6 beat read", a);
    end
    issue(0, 0, 0, 0, 1, 2'b11, 18'h2AAAA);
    issue(0, 0, 0, 0, 1, 2'b00, '0);
    @(negedge clk);
    check("R6 read past burst end", '0, 1'b0);
    issue(1, 1, 0, 5, 0, 2'b00, '0);
    expect_data("R6 write past burst end ignored", 5);

    // R3: starts with chip enable low
    issue(0, 1, 0, 9, 0, 2'b11, 18'h15555);
    issue(0, 0, 1, 9, 0, 2'b00, '0);
    @(negedge clk);
    check("R3 no read without ce", '0, 1'b0);
    issue(1, 0, 1, 9, 0, 2'b00, '0);
    expect_data("R3 no write without ce", 9);

    // R5: start and advance together
    issue(1, 1, 0, 20, 0, 2'b00, '0);
    expect_data("R5 setup", 20);
    issue(1, 0, 1, 42, 1, 2'b00, '0);
    expect_data("R5 start beats adv", 42);
    issue(0, 0, 0, 0, 1, 2'b00, '0);
    expect_data("R5 burst from new base", 43);

    // R8: single-lane writes
    d = 18'h3FFFF;
    issue(1, 1, 0, 12, 0, 2'b01, d);
    model[12] = merge(model[12], d, 2'b01);
    issue(1, 1, 0, 12, 0, 2'b00, '0);
    expect_data("R8 low lane only", 12);
    d = 18'h00000;
    issue(1, 0, 1, 13, 0, 2'b10, d);
    model[13] = merge(model[13], d, 2'b10);
    issue(1, 0, 1, 13, 0, 2'b00, '0);
    expect_data("R8 high lane only", 13);
    // lane writes along a burst
    a = 30;
    d = pat(a, 3);
    issue(1, 1, 0, a, 0, 2'b10, d);
    model[a] = merge(model[a], d, 2'b10);
    a = nxt(a);
    d = pat(a, 3);
    issue(0, 0, 0, 0, 1, 2'b01, d);
    model[a] = merge(model[a], d, 2'b01);
    issue(1, 1, 0, 30, 0, 2'b00, '0);
    expect_data("R8 burst lane write beat0", 30);
    issue(0, 0, 0, 0, 1, 2'b00, '0);
    expect_data("R8 burst lane write beat1", 31);

    // R10: asynchronous output enable
    oe = 1'b0;
    #1;
    check("R10 oe low", '0, 1'b0);
    oe = 1'b1;
    #1;
    check("R10 oe restored", model[31], 1'b1);

    // R11: write presented without a clock edge
    @(negedge clk);
    issue(1, 1, 0, 7, 0, 2'b00, '0);
    @(negedge clk);
    ce = 1; ts_cpu = 1; addr = AW'(7); lane_we = 2'b11; din = model[7];
    #1;
    check("R11 write blocks drive", '0, 1'b0);
    idle_in();
    #0.5;
    check("R11 drive back after write", model[7], 1'b1);

    summary();
  end
endmodule